// File: doc/BRIEF.md
# Sync-Pattern Error Serializer

This block estimates the bit error rate of a running telemetry link without a reference data stream. The only reference it uses is the frame sync code. Each time the frame synchronizer finds sync while in lock, an upstream comparator presents a mismatch vector. That vector holds one bit per sync-code bit, set where the received bit differs from the expected code. The block captures the vector in parallel in a single bit time. In the following bit times it shifts the vector out serially, MSB first, and counts every 1 that leaves the register.

Zeros enter the register behind the data, so after K shifts the register holds zeros with no explicit clear. Shifting runs on the bit-time enable from the first bit after the load until the frame-end strobe. Two counters accumulate: the number of sync bits found in error, and the number of sync fields checked. Downstream logic divides one by the other to get the error ratio.

Top module: `sync_err_serializer`

## Requirements
- R1: After a synchronous reset, the serial error output, the error count and the frames-checked count are all zero.
- R2: On a bit time (bit_en_i high) where sync_i and lock_i are both high, mismatch_i is captured in parallel. No serial bit is emitted in that bit time, so err_bit_o is low in the following cycle.
- R3: After a load, each later bit time presents one register bit, starting with bit K-1 and moving down. err_bit_o is high in the clock cycle after a bit time whose presented bit is 1.
- R4: Each emitted 1 adds one to err_cnt_o, and the count changes in the same cycle that err_bit_o goes high. When a frame lasts at least K bit times after its load, the growth of err_cnt_o over that frame equals the number of 1s in the loaded vector.
- R5: Zeros are shifted in at bit 0. Once K bits have been shifted out, further bit times in the same frame emit 0.
- R6: The bit time that carries frame_end_i still shifts one bit. Shifting then stops, and bits that have not been shifted out are not counted in later bit times until the next load.
- R7: A load takes priority. It overwrites any bits still in the register, and a load in a bit time that also carries frame_end_i starts shifting as normal.
- R8: A sync_i strobe while lock_i is low loads nothing, starts no shifting and leaves frm_cnt_o unchanged.
- R9: frm_cnt_o increases by exactly one for each load.
- R10: In a cycle with bit_en_i low, no state changes: err_bit_o is low in the next cycle and both counts hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en_i | input | 1 | Bit-time enable, one pulse per received bit |
| lock_i | input | 1 | Frame synchronizer reports lock |
| sync_i | input | 1 | Sync window strobe (sync detected this bit) |
| frame_end_i | input | 1 | Last bit time of the frame |
| mismatch_i | input | K | Per-bit sync mismatch vector, 1 = bit in error |
| err_bit_o | output | 1 | Registered serial error bit |
| err_cnt_o | output | CNT_W | Accumulated sync bit errors |
| frm_cnt_o | output | FRM_W | Accumulated sync fields checked |

## Verification
All three outputs are registered, so every result from a bit time is due one clock edge after that bit time. The load count rises after the sync bit. The first serial bit appears after the next enabled bit, and the error count rises in the same cycle as the error bit it counts. The bench drives inputs on the falling edge and steps a requirement-level model at the rising edge. It compares every output on the next falling edge, and checks serial order by counting enabled bit times from the load. Directed frames cover short frames, early frame ends, stalls and loads without lock. The directed checks compare error-count growth against the popcount of the loaded vectors.

// File: rtl/serr_pkg.sv
package serr_pkg;
  // Action taken in the current clock cycle
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,  // no bit time this cycle
    OP_LOAD  = 2'd1,  // parallel capture of mismatch vector
    OP_SHIFT = 2'd2,  // present one bit, shift zero in
    OP_IDLE  = 2'd3   // bit time, register parked
  } serr_op_t;
endpackage

// File: rtl/serr_ctl.sv
module serr_ctl
  import serr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     bit_en_i,
  input  logic     lock_i,
  input  logic     sync_i,
  input  logic     frame_end_i,
  output serr_op_t op_o
);
  logic run_q;

  always_comb begin
    if (!bit_en_i)               op_o = OP_HOLD;
    else if (sync_i && lock_i)   op_o = OP_LOAD;
    else if (run_q)              op_o = OP_SHIFT;
    else                         op_o = OP_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
    end else begin
      unique case (op_o)
        OP_LOAD:  run_q <= 1'b1;
        OP_SHIFT: if (frame_end_i) run_q <= 1'b0;
        default:  run_q <= run_q;
      endcase
    end
  end
endmodule

// File: rtl/serr_shifter.sv
module serr_shifter
  import serr_pkg::*;
#(
  parameter int K = 24
) (
  input  logic           clk,
  input  logic           rst,
  input  serr_op_t       op_i,
  input  logic [K-1:0]   vec_i,
  output logic           head_o,
  output logic           err_bit_o
);
  logic [K-1:0] sh_q;

  assign head_o = sh_q[K-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      err_bit_o <= 1'b0;
    end else begin
      unique case (op_i)
        OP_LOAD: begin
          sh_q      <= vec_i;
          err_bit_o <= 1'b0;
        end
        OP_SHIFT: begin
          sh_q      <= {sh_q[K-2:0], 1'b0};
          err_bit_o <= sh_q[K-1];
        end
        default: begin
          sh_q      <= sh_q;
          err_bit_o <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/serr_counter.sv
module serr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst)        cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sync_err_serializer.sv
module sync_err_serializer
  import serr_pkg::*;
#(
  parameter int K     = 24,
  parameter int CNT_W = 32,
  parameter int FRM_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en_i,
  input  logic             lock_i,
  input  logic             sync_i,
  input  logic             frame_end_i,
  input  logic [K-1:0]     mismatch_i,
  output logic             err_bit_o,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic [FRM_W-1:0] frm_cnt_o
);
  serr_op_t op;
  logic     head;
  logic     err_inc;
  logic     frm_inc;

  serr_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .bit_en_i    (bit_en_i),
    .lock_i      (lock_i),
    .sync_i      (sync_i),
    .frame_end_i (frame_end_i),
    .op_o        (op)
  );

  serr_shifter #(.K(K)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op),
    .vec_i     (mismatch_i),
    .head_o    (head),
    .err_bit_o (err_bit_o)
  );

  assign err_inc = (op == OP_SHIFT) && head;
  assign frm_inc = (op == OP_LOAD);

  serr_counter #(.W(CNT_W)) u_err_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc_i (err_inc),
    .cnt_o (err_cnt_o)
  );

  serr_counter #(.W(FRM_W)) u_frm_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc_i (frm_inc),
    .cnt_o (frm_cnt_o)
  );
endmodule

// File: rtl/sync_err_serializer_chk.sv
module sync_err_serializer_chk #(
  parameter int K     = 24,
  parameter int CNT_W = 32,
  parameter int FRM_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_en_i,
  input logic             lock_i,
  input logic             sync_i,
  input logic             err_bit_o,
  input logic [CNT_W-1:0] err_cnt_o,
  input logic [FRM_W-1:0] frm_cnt_o
);
  a_r4_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (err_cnt_o == $past(err_cnt_o)) || (err_cnt_o == $past(err_cnt_o) + 1'b1));

  a_r4_bit_counted: assert property (@(posedge clk) disable iff (rst)
    err_bit_o |-> (err_cnt_o == $past(err_cnt_o) + 1'b1));

  a_r9_frm_step: assert property (@(posedge clk) disable iff (rst)
    (frm_cnt_o == $past(frm_cnt_o)) || (frm_cnt_o == $past(frm_cnt_o) + 1'b1));

  a_r8_no_load_unlocked: assert property (@(posedge clk) disable iff (rst)
    !lock_i |=> $stable(frm_cnt_o));

  a_r2_quiet_on_load: assert property (@(posedge clk) disable iff (rst)
    (bit_en_i && sync_i && lock_i) |=> !err_bit_o);

  a_r10_stall: assert property (@(posedge clk) disable iff (rst)
    !bit_en_i |=> (!err_bit_o && $stable(err_cnt_o) && $stable(frm_cnt_o)));
endmodule

bind sync_err_serializer sync_err_serializer_chk #(
  .K(K), .CNT_W(CNT_W), .FRM_W(FRM_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_en_i  (bit_en_i),
  .lock_i    (lock_i),
  .sync_i    (sync_i),
  .err_bit_o (err_bit_o),
  .err_cnt_o (err_cnt_o),
  .frm_cnt_o (frm_cnt_o)
);

// File: tb/sync_err_serializer_tb_top.sv
module sync_err_serializer_tb_top;
  localparam int K       = 24;
  localparam int CNT_W   = 32;
  localparam int FRM_W   = 32;
  localparam int CLK_PER = 10;

  logic             clk = 1'b0;
  logic             rst;
  logic             bit_en_i, lock_i, sync_i, frame_end_i;
  logic [K-1:0]     mismatch_i;
  logic             err_bit_o;
  logic [CNT_W-1:0] err_cnt_o;
  logic [FRM_W-1:0] frm_cnt_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // model state
  logic [K-1:0] m_sh;
  bit           m_run;
  bit           m_bit;
  int unsigned  m_err;
  int unsigned  m_frm;

  always #(CLK_PER/2) clk = ~clk;

  sync_err_serializer #(.K(K), .CNT_W(CNT_W), .FRM_W(FRM_W)) dut_i (
    .clk(clk), .rst(rst), .bit_en_i(bit_en_i), .lock_i(lock_i),
    .sync_i(sync_i), .frame_end_i(frame_end_i), .mismatch_i(mismatch_i),
    .err_bit_o(err_bit_o), .err_cnt_o(err_cnt_o), .frm_cnt_o(frm_cnt_o)
  );

  function automatic int popc(input logic [K-1:0] v);
    int c = 0;
    for (int i = 0; i < K; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic chk(input string req, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // One clock: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(input bit en, input bit snc, input bit lk, input bit fe,
                      input logic [K-1:0] v);
    bit_en_i = en; sync_i = snc; lock_i = lk; frame_end_i = fe; mismatch_i = v;
    @(posedge clk);
    m_bit = 0;
    if (en) begin
      if (snc && lk) begin
        m_sh = v; m_run = 1; m_frm++;
      end else if (m_run) begin
        m_bit = m_sh[K-1];
        m_err += int'(m_bit);
        m_sh = m_sh << 1;
        if (fe) m_run = 0;
      end
    end
    @(negedge clk);
    chk("R3 err_bit", longint'(err_bit_o), longint'(m_bit));
    chk("R4 err_cnt", longint'(err_cnt_o), longint'(m_err));
    chk("R9 frm_cnt", longint'(frm_cnt_o), longint'(m_frm));
  endtask

  task automatic bits(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 1, 0, '0);
  endtask

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned e0, f0;
    void'($urandom(32'h5EED_0042));
    rst = 1; bit_en_i = 0; sync_i = 0; lock_i = 0; frame_end_i = 0; mismatch_i = '0;
    m_sh = '0; m_run = 0; m_bit = 0; m_err = 0; m_frm = 0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 err_bit", longint'(err_bit_o), 0);
    chk("R1 err_cnt", longint'(err_cnt_o), 0);
    chk("R1 frm_cnt", longint'(frm_cnt_o), 0);

    // R2/R3/R4/R5: MSB first, full drain, zeros afterwards
    e0 = err_cnt_o;
    step(1, 1, 1, 0, 24'h800001);
    chk("R2 no bit on load", longint'(err_bit_o), 0);
    step(1, 0, 1, 0, '0);
    chk("R3 first bit is MSB", longint'(err_bit_o), 1);
    bits(22);
    step(1, 0, 1, 0, '0);
    chk("R3 last bit is LSB", longint'(err_bit_o), 1);
    bits(4);
    chk("R5 zero fill", longint'(err_bit_o), 0);
    step(1, 0, 1, 1, '0);
    chk("R4 popcount total", longint'(err_cnt_o - e0), 2);

    // R8: sync without lock
    f0 = frm_cnt_o;
    step(1, 1, 0, 0, 24'hFFFFFF);
    bits(30);
    chk("R8 no load without lock frm", longint'(frm_cnt_o - f0), 0);
    chk("R8 no load without lock err", longint'(err_cnt_o - e0), 2);

    // R7: short frame, new load overwrites pending bits
    e0 = err_cnt_o;
    step(1, 1, 1, 0, 24'hFFFFFF);
    bits(5);
    step(1, 1, 1, 0, 24'h000000);
    bits(30);
    chk("R7 overwrite", longint'(err_cnt_o - e0), 5);

    // R6: early frame end stops shifting
    e0 = err_cnt_o;
    step(1, 1, 1, 0, 24'hFFFFFF);
    step(1, 0, 1, 0, '0);
    step(1, 0, 1, 0, '0);
    step(1, 0, 1, 1, '0);
    bits(12);
    chk("R6 stop at frame end", longint'(err_cnt_o - e0), 3);

    // R7: load together with frame end still starts shifting
    e0 = err_cnt_o;
    step(1, 1, 1, 1, 24'h00000F);
    bits(24);
    chk("R7 load beats frame end", longint'(err_cnt_o - e0), 4);

    // R10: stall keeps everything
    e0 = err_cnt_o;
    step(1, 1, 1, 0, 24'hC00000);
    step(1, 0, 1, 0, '0);
    for (int i = 0; i < 5; i++) begin
      step(0, 1, 1, 1, 24'hFFFFFF);
      chk("R10 stall no bit", longint'(err_bit_o), 0);
    end
    step(1, 0, 1, 0, '0);
    chk("R10 resume second bit", longint'(err_bit_o), 1);
    bits(24);
    chk("R10 stall total", longint'(err_cnt_o - e0), 2);

    // random frames
    for (int fr = 0; fr < 300; fr++) begin
      int len;
      bit lk;
      logic [K-1:0] v;
      len = 8 + int'($urandom_range(0, 32));
      lk  = ($urandom_range(0, 7) != 0);
      v   = K'($urandom) & K'($urandom);
      step(1, 1, lk, 0, v);
      for (int b = 1; b < len; b++) begin
        bit en;
        en = ($urandom_range(0, 3) != 0);
        step(en, 0, lk, (b == len - 1), K'($urandom));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule